// File: doc/BRIEF.md
# Split Sum-of-Absolute-Differences Reduction Tree

This block turns 64 pixel pairs into a single sum of absolute differences. It takes one operand set on every clock edge and delivers one result per edge after a fixed delay. Each lane compares its two unsigned 8-bit pixels and steers the larger one and the bit-inverted smaller one into a pipelined carry-save reduction tree. The +1 that would finish each lane's subtraction is not added in the lane. All 64 of these +1 terms go into the tree as one constant operand, so the tree's sum is the true lane total plus a fixed offset of 256 per lane.

A 16x16 block comparison is split across four identical copies of the unit. Each copy handles a quarter of the pixels. A mode input picks each copy's role:

- **Partial role:** the copy only drives its 22-bit partial sum, with the offset included.
- **Combining role:** the copy also captures the partial sums of its three peers alongside its own. It reduces the four values in a second carry-save tree and resolves them in a final adder. The result is a 16-bit value taken modulo 2^16. Because the four offsets add up to exactly 2^16, they cancel and the output is the exact block SAD.

A valid bit travels with the data so that bubbles in the input stream pass through cleanly.

Top module: `sad_split_tree`

## Requirements
- R1: Each lane contributes |a-b| for its unsigned 8-bit pixels. The order of the two pixels does not matter, so a lane with b greater than a gives the same value as the swapped pair.
- R2: When partValid is high, partSum equals the sum of the 64 lane differences plus 64*256 (16384), modulo 2^22. Lane i uses bits [8i+7:8i] of pixA and pixB.
- R3: partValid is high after rising edge m+12 exactly when validIn was high at capture edge m. Whenever partValid is low, partSum is zero.
- R4: In combining role, sadOut equals (local partial + the three 22-bit partial sums on peerSums) modulo 2^16. Peer p sits at bits [22p+21:22p] of peerSums. The peer values are captured on the edge after the local partial appears, which is edge m+13. With all four units fed the same cycle, this gives the full 256-pixel SAD.
- R5: sadValid is high after edge m+28 (29 edges including the capture edge) exactly when validIn and combineMode were both high at capture edge m. Whenever sadValid is low, sadOut is zero.
- R6: Operand sets captured with combineMode low never raise sadValid, and their peerSums have no effect: sadOut stays zero. The partial path of such sets is unaffected.
- R7: A new operand set is accepted on every edge. Back-to-back sets and sets separated by bubbles each produce their own result, in order.
- R8: While rstN is low and after its release, both valid outputs are low and both data outputs are zero until the first captured result emerges.
- R9: The extreme blocks come out exactly: all lanes 255 against 0 gives a SAD of 65280, and identical blocks give 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Active-low synchronous reset of the valid pipeline |
| validIn | input | 1 | Operand set on the pixel buses is valid this edge |
| combineMode | input | 1 | 1 = combining role, 0 = partial role (captured with the operands) |
| pixA | input | 512 | 64 current-block pixels, lane i at [8i+7:8i] |
| pixB | input | 512 | 64 reference-block pixels, lane i at [8i+7:8i] |
| peerSums | input | 66 | Three peer partial sums, peer p at [22p+21:22p] |
| partSum | output | 22 | Offset partial sum of this unit's 64 lanes |
| partValid | output | 1 | partSum carries a result |
| sadOut | output | 16 | Resolved block SAD (combining role) |
| sadValid | output | 1 | sadOut carries a result |

## Verification
The assertions check on every cycle that both data outputs are zero whenever their valid is low, and that every valid partial sum lies inside the window set by the per-lane offset. They also check, through idle counters, that no partial result appears more than 12 edges after the last captured input, and that no SAD appears more than 28 edges after the last combining-role input. The exact arithmetic can only be shown by the bench's scenarios, where four units are wired as one split block and compared each cycle against a behavioural SAD model. The same holds for the exact 13- and 29-edge alignment, peer-sum alignment, the cancellation of the offsets, the ignored peers in partial role, and the extreme blocks.

// File: rtl/sad_tree_pkg.sv
package sad_tree_pkg;

  // operands left after one layer of 3:2 compressors
  function automatic int stepCount(input int n);
    return (n / 3) * 2 + (n % 3);
  endfunction

  function automatic int termCount(input int n, input int lvl);
    int c;
    c = n;
    for (int i = 0; i < lvl; i++) c = stepCount(c);
    return c;
  endfunction

  function automatic int treeLevels(input int n);
    int c;
    int l;
    c = n;
    l = 0;
    while (c > 2) begin
      c = stepCount(c);
      l++;
    end
    return l;
  endfunction

  // edges from capture to the registered partial sum: lane stage + tree + final adder
  function automatic int partLatency(input int lanes);
    return 2 + treeLevels(2 * lanes + 1);
  endfunction

  typedef struct packed {
    logic partStrobe;
    logic sadStrobe;
  } strobe_t;

endpackage

// File: rtl/sad_lane_array.sv
module sad_lane_array #(
  parameter int LANES = 64,
  parameter int PIX_W = 8
) (
  input  logic                         clk,
  input  logic [LANES*PIX_W-1:0]       pixA,
  input  logic [LANES*PIX_W-1:0]       pixB,
  output logic [LANES-1:0][PIX_W-1:0]  hiTerm,
  output logic [LANES-1:0][PIX_W-1:0]  loInvTerm
);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [PIX_W-1:0] a, b;
    logic aWins;
    assign a = pixA[i*PIX_W +: PIX_W];
    assign b = pixB[i*PIX_W +: PIX_W];
    assign aWins = (a >= b);
    // hi + ~lo + 1 = 2^PIX_W + |a-b|; the +1 is deferred into the tree
    always_ff @(posedge clk) begin
      hiTerm[i]    <= aWins ? a : b;
      loInvTerm[i] <= aWins ? ~b : ~a;
    end
  end

endmodule

// File: rtl/sad_csa_tree.sv
module sad_csa_tree
  import sad_tree_pkg::*;
#(
  parameter int W = 22,
  parameter int N = 129
) (
  input  logic                 clk,
  input  logic [N-1:0][W-1:0]  terms,
  output logic [W-1:0]         sumVec,
  output logic [W-1:0]         carryVec
);

  localparam int LEVELS = treeLevels(N);

  for (genvar k = 0; k <= LEVELS; k++) begin : g_lvl
    localparam int CNT = termCount(N, k);
    logic [CNT-1:0][W-1:0] v;
    if (k == 0) begin : g_src
      assign v = terms;
    end else begin : g_red
      localparam int PREV = termCount(N, k - 1);
      localparam int GRP  = PREV / 3;
      localparam int REM  = PREV % 3;
      logic [CNT-1:0][W-1:0] nxt;
      for (genvar g = 0; g < GRP; g++) begin : g_fa
        logic [W-1:0] x, y, z;
        assign x = g_lvl[k-1].v[3*g];
        assign y = g_lvl[k-1].v[3*g+1];
        assign z = g_lvl[k-1].v[3*g+2];
        assign nxt[2*g]   = x ^ y ^ z;
        assign nxt[2*g+1] = {(x[W-2:0] & y[W-2:0]) | (x[W-2:0] & z[W-2:0]) |
                             (y[W-2:0] & z[W-2:0]), 1'b0};
      end
      for (genvar r = 0; r < REM; r++) begin : g_pass
        assign nxt[2*GRP+r] = g_lvl[k-1].v[3*GRP+r];
      end
      always_ff @(posedge clk) v <= nxt;
    end
  end

  assign sumVec   = g_lvl[LEVELS].v[0];
  assign carryVec = g_lvl[LEVELS].v[1];

endmodule

// File: rtl/sad_datapath.sv
module sad_datapath
  import sad_tree_pkg::*;
#(
  parameter int LANES     = 64,
  parameter int PIX_W     = 8,
  parameter int PART_W    = 22,
  parameter int SAD_W     = 16,
  parameter int PEERS     = 3,
  parameter int TOTAL_LAT = 29
) (
  input  logic                      clk,
  input  strobe_t                   strobe,
  input  logic [LANES*PIX_W-1:0]    pixA,
  input  logic [LANES*PIX_W-1:0]    pixB,
  input  logic [PEERS*PART_W-1:0]   peerSums,
  output logic [PART_W-1:0]         partSum,
  output logic [SAD_W-1:0]          sadOut
);

  localparam int TERMS1   = 2 * LANES + 1;
  localparam int TERMS2   = PEERS + 1;
  localparam int PART_LAT = partLatency(LANES);
  localparam int PAD      = TOTAL_LAT - PART_LAT - 2 - treeLevels(TERMS2);

  logic [LANES-1:0][PIX_W-1:0] hiTerm, loInvTerm;
  logic [TERMS1-1:0][PART_W-1:0] terms1;
  logic [TERMS2-1:0][PART_W-1:0] terms2;
  logic [PART_W-1:0] s1, c1, s2, c2, fullSum;
  logic [PART_W-1:0] partReg;
  logic [SAD_W-1:0]  sadPipe [0:PAD];

  sad_lane_array #(.LANES(LANES), .PIX_W(PIX_W)) u_lanes (
    .clk(clk), .pixA(pixA), .pixB(pixB), .hiTerm(hiTerm), .loInvTerm(loInvTerm)
  );

  for (genvar i = 0; i < LANES; i++) begin : g_terms
    assign terms1[2*i]   = {{(PART_W-PIX_W){1'b0}}, hiTerm[i]};
    assign terms1[2*i+1] = {{(PART_W-PIX_W){1'b0}}, loInvTerm[i]};
  end
  // one +1 per lane, gathered into a single constant operand
  assign terms1[TERMS1-1] = PART_W'(LANES);

  sad_csa_tree #(.W(PART_W), .N(TERMS1)) u_tree1 (
    .clk(clk), .terms(terms1), .sumVec(s1), .carryVec(c1)
  );

  always_ff @(posedge clk) partReg <= s1 + c1;

  // combining stage: local partial plus aligned peer partials
  always_ff @(posedge clk) terms2[0] <= partReg;
  for (genvar p = 0; p < PEERS; p++) begin : g_peer
    always_ff @(posedge clk) terms2[p+1] <= peerSums[p*PART_W +: PART_W];
  end

  sad_csa_tree #(.W(PART_W), .N(TERMS2)) u_tree2 (
    .clk(clk), .terms(terms2), .sumVec(s2), .carryVec(c2)
  );

  assign fullSum = s2 + c2;
  always_ff @(posedge clk) sadPipe[0] <= fullSum[SAD_W-1:0];

  for (genvar d = 1; d <= PAD; d++) begin : g_pad
    always_ff @(posedge clk) sadPipe[d] <= sadPipe[d-1];
  end

  assign partSum = strobe.partStrobe ? partReg : '0;
  assign sadOut  = strobe.sadStrobe ? sadPipe[PAD] : '0;

endmodule

// File: rtl/sad_ctrl.sv
module sad_ctrl
  import sad_tree_pkg::*;
#(
  parameter int PART_LAT  = 13,
  parameter int TOTAL_LAT = 29
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    validIn,
  input  logic    combineMode,
  output strobe_t strobe
);

  logic [PART_LAT-1:0]  partSr;
  logic [TOTAL_LAT-1:0] sadSr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      partSr <= '0;
      sadSr  <= '0;
    end else begin
      partSr <= {partSr[PART_LAT-2:0], validIn};
      sadSr  <= {sadSr[TOTAL_LAT-2:0], validIn & combineMode};
    end
  end

  assign strobe.partStrobe = partSr[PART_LAT-1];
  assign strobe.sadStrobe  = sadSr[TOTAL_LAT-1];

endmodule

// File: rtl/sad_split_tree.sv
module sad_split_tree
  import sad_tree_pkg::*;
#(
  parameter int LANES     = 64,
  parameter int PIX_W     = 8,
  parameter int PART_W    = 22,
  parameter int SAD_W     = 16,
  parameter int PEERS     = 3,
  parameter int TOTAL_LAT = 29
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     validIn,
  input  logic                     combineMode,
  input  logic [LANES*PIX_W-1:0]   pixA,
  input  logic [LANES*PIX_W-1:0]   pixB,
  input  logic [PEERS*PART_W-1:0]  peerSums,
  output logic [PART_W-1:0]        partSum,
  output logic                     partValid,
  output logic [SAD_W-1:0]         sadOut,
  output logic                     sadValid
);

  localparam int PART_LAT = partLatency(LANES);

  strobe_t strobe;

  sad_ctrl #(.PART_LAT(PART_LAT), .TOTAL_LAT(TOTAL_LAT)) u_ctrl (
    .clk(clk), .rstN(rstN), .validIn(validIn), .combineMode(combineMode), .strobe(strobe)
  );

  sad_datapath #(
    .LANES(LANES), .PIX_W(PIX_W), .PART_W(PART_W), .SAD_W(SAD_W),
    .PEERS(PEERS), .TOTAL_LAT(TOTAL_LAT)
  ) u_dp (
    .clk(clk), .strobe(strobe), .pixA(pixA), .pixB(pixB), .peerSums(peerSums),
    .partSum(partSum), .sadOut(sadOut)
  );

  assign partValid = strobe.partStrobe;
  assign sadValid  = strobe.sadStrobe;

endmodule

// File: rtl/sad_split_tree_checker.sv
module sad_split_tree_checker
  import sad_tree_pkg::*;
#(
  parameter int LANES     = 64,
  parameter int PIX_W     = 8,
  parameter int PART_W    = 22,
  parameter int SAD_W     = 16,
  parameter int TOTAL_LAT = 29
) (
  input logic              clk,
  input logic              rstN,
  input logic              validIn,
  input logic              combineMode,
  input logic [PART_W-1:0] partSum,
  input logic              partValid,
  input logic [SAD_W-1:0]  sadOut,
  input logic              sadValid
);

  localparam int PART_LAT = partLatency(LANES);
  localparam int CW       = $clog2(TOTAL_LAT + 2);
  localparam int LO_BOUND = LANES << PIX_W;
  localparam int HI_BOUND = LANES * ((2 << PIX_W) - 1);

  logic [CW-1:0] sinceValid, sinceComb;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sinceValid <= CW'(TOTAL_LAT);
      sinceComb  <= CW'(TOTAL_LAT);
    end else begin
      sinceValid <= validIn ? '0 : ((sinceValid < CW'(TOTAL_LAT)) ? sinceValid + 1'b1 : sinceValid);
      sinceComb  <= (validIn && combineMode) ? '0 :
                    ((sinceComb < CW'(TOTAL_LAT)) ? sinceComb + 1'b1 : sinceComb);
    end
  end

  assert_part_zero_R3: assert property (@(posedge clk) disable iff (!rstN)
    !partValid |-> partSum == '0);

  assert_sad_zero_R5: assert property (@(posedge clk) disable iff (!rstN)
    !sadValid |-> sadOut == '0);

  assert_part_window_R2: assert property (@(posedge clk) disable iff (!rstN)
    partValid |-> (32'(partSum) >= LO_BOUND && 32'(partSum) <= HI_BOUND));

  assert_no_stray_part_R3: assert property (@(posedge clk) disable iff (!rstN)
    (sinceValid >= CW'(PART_LAT)) |-> !partValid);

  assert_partial_role_quiet_R6: assert property (@(posedge clk) disable iff (!rstN)
    (sinceComb >= CW'(TOTAL_LAT)) |-> !sadValid);

endmodule

bind sad_split_tree sad_split_tree_checker #(
  .LANES(LANES), .PIX_W(PIX_W), .PART_W(PART_W), .SAD_W(SAD_W), .TOTAL_LAT(TOTAL_LAT)
) u_chk (
  .clk(clk), .rstN(rstN), .validIn(validIn), .combineMode(combineMode),
  .partSum(partSum), .partValid(partValid), .sadOut(sadOut), .sadValid(sadValid)
);

// File: tb/sad_split_tree_bench.sv
module sad_split_tree_bench;

  localparam int LANES  = 64;
  localparam int PIX_W  = 8;
  localparam int PART_W = 22;
  localparam int SAD_W  = 16;
  localparam int PEERS  = 3;
  localparam int PLAT   = 12;   // edges after capture edge for partial
  localparam int SLAT   = 28;   // edges after capture edge for SAD
  localparam int LAST   = 150;
  localparam int RUN    = 190;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic validIn = 1'b0;
  logic combTop = 1'b0;
  logic [LANES*PIX_W-1:0] aBus [0:3];
  logic [LANES*PIX_W-1:0] bBus [0:3];
  logic [PART_W-1:0] part [0:3];
  logic pValid [0:3];
  logic [SAD_W-1:0] sad [0:3];
  logic sValid [0:3];
  logic [PEERS*PART_W-1:0] peerBus;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  bit hValid [0:RUN+2];
  bit hComb  [0:RUN+2];
  int hPart  [0:RUN+2][0:3];
  int hSad   [0:RUN+2];

  always #5 clk = ~clk;

  assign peerBus = {part[3], part[2], part[1]};

  sad_split_tree u_sad_split_tree (
    .clk(clk), .rstN(rstN), .validIn(validIn), .combineMode(combTop),
    .pixA(aBus[0]), .pixB(bBus[0]), .peerSums(peerBus),
    .partSum(part[0]), .partValid(pValid[0]), .sadOut(sad[0]), .sadValid(sValid[0])
  );

  for (genvar p = 1; p < 4; p++) begin : g_peer
    sad_split_tree u_peer (
      .clk(clk), .rstN(rstN), .validIn(validIn), .combineMode(1'b0),
      .pixA(aBus[p]), .pixB(bBus[p]), .peerSums('0),
      .partSum(part[p]), .partValid(pValid[p]), .sadOut(sad[p]), .sadValid(sValid[p])
    );
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  // build the operand set for capture edge k and record the model's answer
  task automatic drive(input int k);
    int mode;
    int sumAll;
    mode = (k <= 40) ? 0 : (k <= 48) ? 1 : (k <= 56) ? 2 : (k <= 80) ? 3 :
           (k <= 110) ? 4 : (k <= 130) ? 5 : (k <= LAST) ? 0 : 6;
    validIn = (mode == 6) ? 1'b0 : (mode == 3) ? k[0] : 1'b1;
    combTop = (mode != 4);
    sumAll = 0;
    for (int u = 0; u < 4; u++) begin
      int s;
      s = 0;
      for (int l = 0; l < LANES; l++) begin
        int a, b;
        a = int'($urandom_range(255));
        b = int'($urandom_range(255));
        if (mode == 1) begin a = 255; b = 0; end          // R9 maximum
        if (mode == 2) b = a;                               // R9 identical
        if (mode == 5) begin                                // R1 b above a
          a = int'($urandom_range(120));
          b = a + int'($urandom_range(135));
        end
        aBus[u][l*PIX_W +: PIX_W] = PIX_W'(a);
        bBus[u][l*PIX_W +: PIX_W] = PIX_W'(b);
        s += (a > b) ? a - b : b - a;
      end
      sumAll += s;
      hPart[k][u] = (s + LANES * 256) % (1 << PART_W);
    end
    hSad[k]   = sumAll % (1 << SAD_W);
    hValid[k] = validIn;
    hComb[k]  = combTop;
  endtask

  task automatic compare(input int n);
    for (int u = 0; u < 4; u++) begin
      bit ev;
      int ep;
      ev = (n - PLAT >= 1) ? hValid[n-PLAT] : 1'b0;
      ep = ev ? hPart[n-PLAT][u] : 0;
      check(pValid[u] == ev, "R3 R7 partValid", int'(pValid[u]), int'(ev));
      check(int'(part[u]) == ep, "R1 R2 partSum", int'(part[u]), ep);
    end
    begin
      bit es;
      int ed;
      es = (n - SLAT >= 1) ? (hValid[n-SLAT] && hComb[n-SLAT]) : 1'b0;
      ed = es ? hSad[n-SLAT] : 0;
      check(sValid[0] == es, "R5 R6 sadValid", int'(sValid[0]), int'(es));
      check(int'(sad[0]) == ed, "R4 R9 sadOut", int'(sad[0]), ed);
    end
    // peers in partial role never report a SAD: R6
    check(sValid[1] == 1'b0 && sad[1] == '0, "R6 peer sadOut", int'(sad[1]), 0);
  endtask

  initial begin
    for (int u = 0; u < 4; u++) begin
      aBus[u] = '0;
      bBus[u] = '0;
    end
    for (int k = 0; k <= RUN + 2; k++) begin
      hValid[k] = 1'b0;
      hComb[k] = 1'b0;
      hSad[k] = 0;
      for (int u = 0; u < 4; u++) hPart[k][u] = 0;
    end
    repeat (5) @(negedge clk);
    // R8: reset state
    check(sValid[0] == 1'b0 && sad[0] == '0, "R8 reset sad", int'(sad[0]), 0);
    check(pValid[0] == 1'b0 && part[0] == '0, "R8 reset part", int'(part[0]), 0);
    rstN = 1'b1;
    drive(1);
    for (int n = 1; n <= RUN; n++) begin
      @(negedge clk);
      compare(n);
      drive(n + 1);
    end
    finish_run();
  end

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

endmodule